// File: doc/BRIEF.md
# Multi-channel compare-match timer

The block has a small number of independent timer channels behind one synchronous register port. Each channel holds an up-counter, a compare register and a control/status word. Every channel advances on a prescaled tick, and its clock-select field picks the tick. When the count equals the compare value, the channel raises its match flag. In periodic mode the counter also returns to zero, so one period lasts compare + 1 ticks. In free-running mode the counter keeps counting and sets an overflow flag when it wraps past all ones.

A shared run register at offset 0x00 holds one run bit per channel, where bit n belongs to channel n. Channel n has its control/status word at 0x10 + 0x10·n, its counter at +0x4 and its compare register at +0x8. A write to the counter does not complete at once: it stays pending for three clocks, and a status bit shows that it is in flight. Software clears the status flags by writing zero to them. Each channel drives one level interrupt output.

Top module: `match_timer`

## Requirements
- R1: After reset every counter reads 0, every compare register reads 0xFFFFFFFF, every control word and the run register read 0, and every interrupt output is low.
- R2: A channel counts only while its bit in the run register (bit n for channel n) is 1. With the bit at 0 the counter holds its value. Each channel's bit is independent of the others.
- R3: Clock-select field bits 2:0 pick the count rate: code 7 counts every clock, 4 every 8 clocks, 5 every 32 and 6 every 128. Codes 0 to 3 stop counting.
- R4: With periodic mode (control bit 8) set, a tick at count == compare loads 0 and sets the match flag. Counting from 0 at one count per clock, the flag appears C+1 clocks after the run bit is written, where C is the compare value.
- R5: With bit 8 clear, a tick at count == compare sets the match flag (bit 15) and the count goes on to compare + 1. A tick at count all ones wraps the count to 0 and sets the overflow flag (bit 14).
- R6: A counter write is pending for three clocks, and control bit 13 reads 1 during that time. A counter read in that window returns the old count. From the next clock on, bit 13 reads 0 and the counter reads the written value.
- R7: A counter write that arrives while bit 13 is 1 is discarded.
- R8: A control write with 0 in bit 15 or bit 14 clears that flag. A 1 in either bit leaves that flag as it was. Bit 13 is read-only.
- R9: If a match and a clearing control write happen in the same clock, the match flag stays set.
- R10: A channel's interrupt output is high exactly while its match flag is 1, its interrupt enable (bit 7) is 1 and its request select (bits 5:4) is 2'b10. The codes 2'b00 (none) and 2'b01 (DMA) keep it low.
- R11: Writes to the control and compare registers take effect at the clock that takes them. A read strobe registers the addressed value, which then appears on the read-data output.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wrEn | input | 1 | Register write strobe |
| rdEn | input | 1 | Register read strobe |
| addr | input | ADDR_W | Register byte address |
| wrData | input | DATA_W | Write data |
| rdData | output | DATA_W | Registered read data |
| irq | output | NUM_CH | Per-channel level interrupt request |

## Verification
Three internal faults each show up at the ports at a known clock. A pending-write counter that is off by one moves the clock at which bit 13 drops, and the new counter value becomes readable at that same clock. A wrong prescaler tap or a wrong tick gate changes how much a counter grows over a 256-clock window, and a single read pair shows it. A wrong order between the match and the clear, or a wrong reload to zero, shifts or drops the interrupt edge. The bench checks that edge one clock either side of the expected match, over randomly chosen compare values on both channels.

// File: rtl/match_timer_pkg.sv
package match_timer_pkg;
  // control/status word field positions
  localparam int BIT_MATCH    = 15;
  localparam int BIT_OVF      = 14;
  localparam int BIT_WIP      = 13;
  localparam int BIT_PERIODIC = 8;
  localparam int BIT_IE       = 7;
  localparam int REQ_LO       = 4;
  localparam int CKS_LO       = 0;

  localparam logic [1:0] REQ_IRQ = 2'b10;

  localparam logic [2:0] CKS_DIV8   = 3'd4;
  localparam logic [2:0] CKS_DIV32  = 3'd5;
  localparam logic [2:0] CKS_DIV128 = 3'd6;
  localparam logic [2:0] CKS_DIV1   = 3'd7;

  // prescaler taps: 0 every clock, 1 /8, 2 /32, 3 /128
  localparam int NUM_DIV = 4;
  localparam int PRE_W   = 7;

  // address map (byte offsets)
  localparam int CH_BASE   = 16;
  localparam int CH_STRIDE = 16;
  localparam int OFS_CNT   = 4;
  localparam int OFS_CMP   = 8;

  typedef struct packed {
    logic tick;
    logic periodic;
    logic cntLoad;
    logic cmpWr;
    logic clrMatch;
    logic clrOvf;
  } chanStrobe_t;

  typedef struct packed {
    logic       periodic;
    logic       irqEn;
    logic [1:0] reqSel;
    logic [2:0] clkSel;
  } chanMode_t;
endpackage

// File: rtl/match_timer_ctrl.sv
module match_timer_ctrl
  import match_timer_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int CH_IDX = 0,
  parameter int WR_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  input  logic              runBit,
  input  logic [NUM_DIV-1:0] divTick,
  output chanStrobe_t       strobe,
  output logic [CNT_W-1:0]  loadVal,
  output chanMode_t         mode,
  output logic              wip
);
  localparam int BUSY_W = $clog2(WR_LAT + 1);
  localparam logic [ADDR_W-1:0] BASE    = ADDR_W'(CH_BASE + CH_STRIDE * CH_IDX);
  localparam logic [ADDR_W-1:0] CNT_ADR = ADDR_W'(CH_BASE + CH_STRIDE * CH_IDX + OFS_CNT);
  localparam logic [ADDR_W-1:0] CMP_ADR = ADDR_W'(CH_BASE + CH_STRIDE * CH_IDX + OFS_CMP);

  logic selCtrl, selCnt, selCmp, cntAccept, rateTick;
  logic [BUSY_W-1:0] busyCnt;

  assign selCtrl   = wrEn && (addr == BASE);
  assign selCnt    = wrEn && (addr == CNT_ADR);
  assign selCmp    = wrEn && (addr == CMP_ADR);
  assign cntAccept = selCnt && (busyCnt == '0);
  assign wip       = (busyCnt != '0);

  always_ff @(posedge clk) begin
    if (rst) begin
      busyCnt <= '0;
      loadVal <= '0;
      mode    <= '0;
    end else begin
      if (cntAccept) begin
        busyCnt <= BUSY_W'(WR_LAT);
        loadVal <= wrData[CNT_W-1:0];
      end else if (busyCnt != '0) begin
        busyCnt <= busyCnt - 1'b1;
      end
      if (selCtrl) begin
        mode.periodic <= wrData[BIT_PERIODIC];
        mode.irqEn    <= wrData[BIT_IE];
        mode.reqSel   <= wrData[REQ_LO +: 2];
        mode.clkSel   <= wrData[CKS_LO +: 3];
      end
    end
  end

  always_comb begin
    case (mode.clkSel)
      CKS_DIV1:   rateTick = divTick[0];
      CKS_DIV8:   rateTick = divTick[1];
      CKS_DIV32:  rateTick = divTick[2];
      CKS_DIV128: rateTick = divTick[3];
      default:    rateTick = 1'b0;
    endcase
  end

  always_comb begin
    strobe.tick     = runBit && rateTick;
    strobe.periodic = mode.periodic;
    strobe.cntLoad  = (busyCnt == BUSY_W'(1));
    strobe.cmpWr    = selCmp;
    strobe.clrMatch = selCtrl && !wrData[BIT_MATCH];
    strobe.clrOvf   = selCtrl && !wrData[BIT_OVF];
  end

  // R7: a counter write during a pending one does not touch the pending value
  assert_busy_write_dropped_R7: assert property (@(posedge clk) disable iff (rst)
    (wip && selCnt) |=> $stable(loadVal));

  // R6: an accepted counter write shows write-in-progress on the next cycle
  assert_wip_raised_R6: assert property (@(posedge clk) disable iff (rst)
    cntAccept |=> wip);

  // R6: once the load strobe fires the pending state is over
  assert_wip_done_R6: assert property (@(posedge clk) disable iff (rst)
    strobe.cntLoad |=> !wip);
endmodule

// File: rtl/match_timer_dp.sv
module match_timer_dp
  import match_timer_pkg::*;
#(
  parameter int CNT_W = 32
) (
  input  logic             clk,
  input  logic             rst,
  input  chanStrobe_t      strobe,
  input  logic [CNT_W-1:0] loadVal,
  input  logic [CNT_W-1:0] cmpData,
  output logic [CNT_W-1:0] count,
  output logic [CNT_W-1:0] cmpVal,
  output logic             matchFlag,
  output logic             ovfFlag
);
  logic hit, atMax, matchEvt, ovfEvt;

  assign hit      = (count == cmpVal);
  assign atMax    = &count;
  assign matchEvt = strobe.tick && hit;
  assign ovfEvt   = strobe.tick && atMax && !(hit && strobe.periodic);

  always_ff @(posedge clk) begin
    if (rst) begin
      count     <= '0;
      cmpVal    <= '1;
      matchFlag <= 1'b0;
      ovfFlag   <= 1'b0;
    end else begin
      if (strobe.cntLoad)
        count <= loadVal;
      else if (strobe.tick)
        count <= (hit && strobe.periodic) ? '0 : count + 1'b1;
      if (strobe.cmpWr)
        cmpVal <= cmpData;
      if (matchEvt)
        matchFlag <= 1'b1;
      else if (strobe.clrMatch)
        matchFlag <= 1'b0;
      if (ovfEvt)
        ovfFlag <= 1'b1;
      else if (strobe.clrOvf)
        ovfFlag <= 1'b0;
    end
  end

  // R6: the pending value lands in the counter
  assert_load_lands_R6: assert property (@(posedge clk) disable iff (rst)
    strobe.cntLoad |=> (count == $past(loadVal)));

  // R2: no tick and no load means the count holds
  assert_hold_without_tick_R2: assert property (@(posedge clk) disable iff (rst)
    (!strobe.tick && !strobe.cntLoad) |=> $stable(count));

  // R9: a match always leaves the flag set, even against a clearing write
  assert_match_wins_R9: assert property (@(posedge clk) disable iff (rst)
    matchEvt |=> matchFlag);

  // R4: periodic match returns the counter to zero
  assert_periodic_wrap_R4: assert property (@(posedge clk) disable iff (rst)
    (matchEvt && strobe.periodic && !strobe.cntLoad) |=> (count == '0));

  // R8: a clearing write with no match drops the flag
  assert_clear_works_R8: assert property (@(posedge clk) disable iff (rst)
    (strobe.clrMatch && !matchEvt) |=> !matchFlag);
endmodule

// File: rtl/match_timer.sv
module match_timer
  import match_timer_pkg::*;
#(
  parameter int NUM_CH = 2,
  parameter int ADDR_W = 8,
  parameter int DATA_W = 32,
  parameter int CNT_W  = 32,
  parameter int WR_LAT = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              wrEn,
  input  logic              rdEn,
  input  logic [ADDR_W-1:0] addr,
  input  logic [DATA_W-1:0] wrData,
  output logic [DATA_W-1:0] rdData,
  output logic [NUM_CH-1:0] irq
);
  logic [NUM_CH-1:0]  runBits;
  logic [PRE_W-1:0]   preCnt;
  logic [NUM_DIV-1:0] divTick;
  logic [DATA_W-1:0]  ctrlRd [NUM_CH];
  logic [DATA_W-1:0]  cntRd  [NUM_CH];
  logic [DATA_W-1:0]  cmpRd  [NUM_CH];
  logic [DATA_W-1:0]  rdNext;

  always_ff @(posedge clk) begin
    if (rst) begin
      preCnt  <= '0;
      runBits <= '0;
    end else begin
      preCnt <= preCnt + 1'b1;
      if (wrEn && addr == '0)
        runBits <= wrData[NUM_CH-1:0];
    end
  end

  assign divTick[0] = 1'b1;
  assign divTick[1] = &preCnt[2:0];
  assign divTick[2] = &preCnt[4:0];
  assign divTick[3] = &preCnt[6:0];

  for (genvar n = 0; n < NUM_CH; n++) begin : gChan
    chanStrobe_t      strobe;
    chanMode_t        mode;
    logic [CNT_W-1:0] loadVal, count, cmpVal;
    logic             wip, matchFlag, ovfFlag;

    match_timer_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W), .CH_IDX(n), .WR_LAT(WR_LAT)
    ) u_ctrl (
      .clk(clk), .rst(rst), .wrEn(wrEn), .addr(addr), .wrData(wrData),
      .runBit(runBits[n]), .divTick(divTick), .strobe(strobe),
      .loadVal(loadVal), .mode(mode), .wip(wip)
    );

    match_timer_dp #(.CNT_W(CNT_W)) u_dp (
      .clk(clk), .rst(rst), .strobe(strobe), .loadVal(loadVal),
      .cmpData(wrData[CNT_W-1:0]), .count(count), .cmpVal(cmpVal),
      .matchFlag(matchFlag), .ovfFlag(ovfFlag)
    );

    assign irq[n] = matchFlag && mode.irqEn && (mode.reqSel == REQ_IRQ);

    always_comb begin
      ctrlRd[n]                 = '0;
      ctrlRd[n][BIT_MATCH]      = matchFlag;
      ctrlRd[n][BIT_OVF]        = ovfFlag;
      ctrlRd[n][BIT_WIP]        = wip;
      ctrlRd[n][BIT_PERIODIC]   = mode.periodic;
      ctrlRd[n][BIT_IE]         = mode.irqEn;
      ctrlRd[n][REQ_LO +: 2]    = mode.reqSel;
      ctrlRd[n][CKS_LO +: 3]    = mode.clkSel;
    end
    assign cntRd[n] = DATA_W'(count);
    assign cmpRd[n] = DATA_W'(cmpVal);
  end

  always_comb begin
    rdNext = '0;
    if (addr == '0)
      rdNext = DATA_W'(runBits);
    for (int n = 0; n < NUM_CH; n++) begin
      if (addr == ADDR_W'(CH_BASE + CH_STRIDE * n))           rdNext = ctrlRd[n];
      if (addr == ADDR_W'(CH_BASE + CH_STRIDE * n + OFS_CNT)) rdNext = cntRd[n];
      if (addr == ADDR_W'(CH_BASE + CH_STRIDE * n + OFS_CMP)) rdNext = cmpRd[n];
    end
  end

  always_ff @(posedge clk) begin
    if (rst)
      rdData <= '0;
    else if (rdEn)
      rdData <= rdNext;
  end
endmodule

// File: tb/match_timer_tb.sv
`timescale 1ns/1ps
module match_timer_tb;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic wrEn = 1'b0, rdEn = 1'b0;
  logic [7:0]  addr = '0;
  logic [31:0] wrData = '0;
  logic [31:0] rdData;
  logic [1:0]  irq;
  int tests = 0, fails = 0;
  bit done = 0;

  always #4 clk = ~clk;

  match_timer u_dut (
    .clk(clk), .rst(rst), .wrEn(wrEn), .rdEn(rdEn), .addr(addr),
    .wrData(wrData), .rdData(rdData), .irq(irq)
  );

  function automatic logic [7:0] ctrlA(input int ch); return 8'(16 + 16 * ch); endfunction
  function automatic logic [7:0] cntA(input int ch);  return 8'(20 + 16 * ch); endfunction
  function automatic logic [7:0] cmpA(input int ch);  return 8'(24 + 16 * ch); endfunction

  // control word: keepM/keepO write 1 into the flag bits (no clear)
  function automatic logic [31:0] mkCtrl(input bit keepM, input bit keepO, input bit per,
                                         input bit ie, input logic [1:0] req, input logic [2:0] cks);
    return (32'(keepM) << 15) | (32'(keepO) << 14) | (32'(per) << 8) | (32'(ie) << 7) |
           (32'(req) << 4) | 32'(cks);
  endfunction

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // both tasks start and end just after a falling edge
  task automatic writeReg(input logic [7:0] a, input logic [31:0] d);
    addr = a; wrData = d; wrEn = 1'b1;
    @(negedge clk);
    wrEn = 1'b0;
  endtask

  task automatic readReg(input logic [7:0] a, output logic [31:0] d);
    addr = a; rdEn = 1'b1;
    @(negedge clk);
    rdEn = 1'b0;
    d = rdData;
  endtask

  task automatic rateDiff(input int ch, output logic [31:0] diff);
    logic [31:0] v1, v2;
    readReg(cntA(ch), v1);
    repeat (255) @(negedge clk);
    readReg(cntA(ch), v2);
    diff = v2 - v1;
  endtask

  initial begin
    repeat (2_000_000 / 8) @(posedge clk);
    if (!done) begin
      tests++; fails++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [31:0] v, old, d;
    int c, ch;
    void'($urandom(32'd1234));
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);

    // R1 reset state
    readReg(8'h00, v);    check("R1 run reg", v, 32'h0);
    readReg(ctrlA(0), v); check("R1 ctrl0", v, 32'h0);
    readReg(cntA(0), v);  check("R1 cnt0", v, 32'h0);
    readReg(cmpA(0), v);  check("R1 cmp0", v, 32'hFFFF_FFFF);
    readReg(cmpA(1), v);  check("R1 cmp1", v, 32'hFFFF_FFFF);
    check("R1 irq", 32'(irq), 32'h0);

    // R11 compare and control writes read back; flag bits written 1 stay 0 (R8)
    writeReg(cmpA(0), 32'h0000_1234);
    readReg(cmpA(0), v); check("R11 cmp readback", v, 32'h0000_1234);
    writeReg(ctrlA(0), mkCtrl(1, 1, 1, 1, 2'b10, 3'd5));
    readReg(ctrlA(0), v); check("R11 ctrl readback", v, mkCtrl(0, 0, 1, 1, 2'b10, 3'd5));

    // R3 rates, R2 run gating
    writeReg(cmpA(0), 32'hFFFF_FFFF);
    writeReg(ctrlA(0), mkCtrl(1, 1, 0, 0, 2'b00, 3'd7));
    writeReg(ctrlA(1), mkCtrl(1, 1, 0, 0, 2'b00, 3'd7));
    writeReg(8'h00, 32'h1);
    readReg(8'h00, v); check("R2 run readback", v, 32'h1);
    rateDiff(0, d); check("R3 div1", d, 32'd256);
    rateDiff(1, d); check("R2 ch1 idle", d, 32'd0);
    writeReg(ctrlA(0), mkCtrl(1, 1, 0, 0, 2'b00, 3'd4));
    rateDiff(0, d); check("R3 div8", d, 32'd32);
    writeReg(ctrlA(0), mkCtrl(1, 1, 0, 0, 2'b00, 3'd5));
    rateDiff(0, d); check("R3 div32", d, 32'd8);
    writeReg(ctrlA(0), mkCtrl(1, 1, 0, 0, 2'b00, 3'd6));
    rateDiff(0, d); check("R3 div128", d, 32'd2);
    for (int k = 0; k < 4; k++) begin
      writeReg(ctrlA(0), mkCtrl(1, 1, 0, 0, 2'b00, 3'(k)));
      rateDiff(0, d); check("R3 stopped code", d, 32'd0);
    end
    writeReg(ctrlA(0), mkCtrl(1, 1, 0, 0, 2'b00, 3'd7));
    writeReg(8'h02, 32'h2);
    writeReg(8'h00, 32'h2);
    rateDiff(0, d); check("R2 ch0 stopped", d, 32'd0);
    rateDiff(1, d); check("R2 ch1 runs", d, 32'd256);
    writeReg(8'h00, 32'h0);

    // R6 pending counter write
    readReg(cntA(0), old);
    writeReg(cntA(0), 32'hABCD_0001);
    readReg(ctrlA(0), v); check("R6 wip first", (v >> 13) & 1, 32'd1);
    readReg(cntA(0), v);  check("R6 old value during wip", v, old);
    readReg(ctrlA(0), v); check("R6 wip third", (v >> 13) & 1, 32'd1);
    readReg(ctrlA(0), v); check("R6 wip cleared", (v >> 13) & 1, 32'd0);
    readReg(cntA(0), v);  check("R6 new value", v, 32'hABCD_0001);

    // R7 second write during wip is dropped
    writeReg(cntA(0), 32'h0000_0111);
    writeReg(cntA(0), 32'h0000_0222);
    repeat (4) @(negedge clk);
    readReg(cntA(0), v); check("R7 busy write dropped", v, 32'h0000_0111);
    writeReg(cntA(0), 32'h0000_0222);
    repeat (4) @(negedge clk);
    readReg(cntA(0), v); check("R7 later write taken", v, 32'h0000_0222);

    // R5 free-running: overflow and match without clear
    writeReg(ctrlA(0), mkCtrl(0, 0, 0, 0, 2'b00, 3'd7));
    writeReg(cmpA(0), 32'd5);
    writeReg(cntA(0), 32'hFFFF_FFFD);
    repeat (4) @(negedge clk);
    writeReg(8'h00, 32'h1);            // edge E0
    repeat (2) @(negedge clk);         // E1, E2
    readReg(ctrlA(0), v); check("R5 ovf not yet", (v >> 14) & 1, 32'd0);  // E3
    readReg(ctrlA(0), v); check("R5 ovf set", (v >> 14) & 3, 32'd1);      // E4
    repeat (6) @(negedge clk);
    writeReg(8'h00, 32'h0);            // E11
    readReg(cntA(0), v);  check("R5 counts past compare", v, 32'd8);
    readReg(ctrlA(0), v); check("R5 both flags", (v >> 14) & 3, 32'd3);

    // R8 flag clearing
    writeReg(ctrlA(0), mkCtrl(1, 1, 0, 0, 2'b00, 3'd7));
    readReg(ctrlA(0), v); check("R8 write one keeps", (v >> 14) & 3, 32'd3);
    writeReg(ctrlA(0), mkCtrl(0, 1, 0, 0, 2'b00, 3'd7));
    readReg(ctrlA(0), v); check("R8 clear match only", (v >> 14) & 3, 32'd1);
    writeReg(ctrlA(0), mkCtrl(1, 0, 0, 0, 2'b00, 3'd7));
    readReg(ctrlA(0), v); check("R8 clear ovf", (v >> 14) & 3, 32'd0);

    // R10 interrupt gating
    writeReg(ctrlA(0), mkCtrl(0, 0, 1, 1, 2'b01, 3'd7));
    writeReg(cmpA(0), 32'd3);
    writeReg(cntA(0), 32'd0);
    repeat (4) @(negedge clk);
    writeReg(8'h00, 32'h1);
    repeat (10) @(negedge clk);
    writeReg(8'h00, 32'h0);
    check("R10 dma select no irq", 32'(irq[0]), 32'd0);
    readReg(ctrlA(0), v); check("R10 flag set", (v >> 15) & 1, 32'd1);
    writeReg(ctrlA(0), mkCtrl(1, 1, 1, 1, 2'b10, 3'd7));
    check("R10 irq select", 32'(irq[0]), 32'd1);
    writeReg(ctrlA(0), mkCtrl(1, 1, 1, 0, 2'b10, 3'd7));
    check("R10 enable off", 32'(irq[0]), 32'd0);
    writeReg(ctrlA(0), mkCtrl(1, 1, 1, 1, 2'b00, 3'd7));
    check("R10 none select", 32'(irq[0]), 32'd0);
    writeReg(ctrlA(0), mkCtrl(0, 0, 1, 1, 2'b10, 3'd7));
    check("R10 cleared flag", 32'(irq[0]), 32'd0);

    // R4 period timing and R9 match-vs-clear, random compare values
    for (int i = 0; i < 10; i++) begin
      ch = i % 2;
      c = 2 + int'($urandom % 30);
      writeReg(8'h00, 32'h0);
      writeReg(ctrlA(ch), mkCtrl(0, 0, 1, 1, 2'b10, 3'd7));
      writeReg(cmpA(ch), 32'(c));
      writeReg(cntA(ch), 32'd0);
      repeat (4) @(negedge clk);
      writeReg(8'h00, 32'(1 << ch));   // E0
      repeat (c) @(negedge clk);       // after E(c)
      check("R4 no match before C+1", 32'(irq[ch]), 32'd0);
      @(negedge clk);                  // after E(c+1)
      check("R4 match at C+1", 32'(irq[ch]), 32'd1);
      writeReg(ctrlA(ch), mkCtrl(0, 1, 1, 1, 2'b10, 3'd7));  // E(c+2)
      check("R8 clear while running", 32'(irq[ch]), 32'd0);
      repeat (c - 1) @(negedge clk);   // after E(2c+1)
      writeReg(ctrlA(ch), mkCtrl(0, 1, 1, 1, 2'b10, 3'd7));  // E(2c+2) = match
      check("R9 match beats clear", 32'(irq[ch]), 32'd1);
      writeReg(ctrlA(ch), mkCtrl(0, 1, 1, 1, 2'b10, 3'd7));  // E(2c+3)
      check("R9 later clear", 32'(irq[ch]), 32'd0);
    end
    writeReg(8'h00, 32'h0);

    done = 1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule